// File: doc/BRIEF.md
# Variable-length instruction predecoder

This block sits between an instruction fetch buffer and the execute stage of a CPU whose instructions are byte-aligned and run from one to seven bytes long. Each cycle it looks at a window of fetched bytes that starts at the current program counter. It sorts the first byte into a format class, which fixes the instruction length. It then builds a normalized 32-bit instruction word and a 24-bit extension field from the window.

The operand bytes follow their own byte order. Embedded immediates are little-endian, but some long forms are packed big-endian. Each length class splits the bytes between the word and the extension in its own way. Inside the 0x80–0xbf range, the length depends on whether the two 2-bit register fields of the opcode are equal.

The decoded result is held in one output register stage with a valid/ready handshake. The stage also carries the address of the following instruction. A window is taken from the fetch buffer only when at least seven of its bytes are valid.

Top module: `insn_predecode`

## Requirements
- R1: While reset is high and in the first cycle after it, `dec_valid` is 0. With no window offered, `fetch_take` is 0.
- R2: A window is taken (`fetch_take`=1) only when `fetch_avail` is at least 7 and the output stage is empty or is being drained by `dec_ready`. The decoded result shows on the outputs one cycle after the take. When no window is taken and `dec_ready` is 1, `dec_valid` falls.
- R3: While `dec_valid`=1 and `dec_ready`=0, all outputs keep their values and no window is taken. If the stage is drained while a new window is offered in the same cycle, that window is decoded in the next cycle.
- R4: One-byte opcodes give length 1, a word equal to the opcode byte and an extension of 0. These opcodes are:
  - 0x00, 0x04, 0x08, 0x0c
  - 0x10–0x1f, 0x3c–0x3f
  - 0x40, 0x41, 0x44, 0x45, 0x48, 0x49, 0x4c, 0x4d
  - 0x50–0x57, 0x60–0x7f
  - 0xcb, 0xd0–0xdb, 0xe0–0xef, 0xff
  - every byte in 0x80–0xbf whose bits [3:2] differ from its bits [1:0]
- R5: Two-byte opcodes give length 2, word = byte0·2^8 + byte1 and extension 0. These opcodes are:
  - 0x20–0x23, 0x28–0x2b
  - 0x42, 0x43, 0x46, 0x47, 0x4a, 0x4b, 0x4e, 0x4f
  - 0x58–0x5f, 0xc0–0xca, 0xce, 0xcf, 0xf0–0xf6
  - every byte in 0x80–0xbf whose bits [3:2] equal its bits [1:0]
- R6: Three-byte opcodes with a little-endian 16-bit operand give length 3, word = byte0·2^16 + byte2·2^8 + byte1 and extension 0. These opcodes are 0x01–0x03, 0x05–0x07, 0x09–0x0b, 0x0d–0x0f, 0x24–0x27, 0x2c–0x3b and 0xcc.
- R7: Opcodes 0xde, 0xdf, 0xf8 and 0xf9 give length 3, the word byte0·2^16 + byte1·2^8 + byte2, and extension 0.
- R8: Opcodes 0xfa and 0xfb give length 4 and extension 0. If byte0 is 0xfa and byte1 is in 0xf0–0xfb, the word is bytes 0..3 big-endian. Otherwise the word is byte0, byte1, byte3, byte2 from the most significant byte down.
- R9: Opcode 0xcd gives length 5, the word byte0, byte2, byte1, byte3 (most significant first) and extension byte4. Opcode 0xdc gives length 5, the word byte0, byte4, byte3, byte2 and extension byte1.
- R10: Opcodes 0xfc and 0xfd give length 6, the word byte0, byte1, byte5, byte4 and extension byte3·2^8 + byte2.
- R11: Opcode 0xdd gives length 7, the word byte0, byte4, byte3, byte2 and extension byte1, byte5, byte6. Opcode 0xfe gives length 7, the word byte0, byte1, byte5, byte4 and extension byte3, byte2, byte6.
- R12: Every other opcode byte (only 0xf7) sets `dec_illegal`=1 with length 0, word 0 and extension 0. A legal decode has `dec_illegal`=0 and a nonzero length.
- R13: `dec_next_pc` equals the `fetch_pc` of the taken window plus the decoded length, modulo 2^PC_W. For an illegal opcode it equals that `fetch_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_bytes | input | 8*WIN_BYTES | Fetch window; byte i sits at bits [8i+7:8i], byte 0 is at the PC |
| fetch_avail | input | clog2(WIN_BYTES+1) | Number of valid bytes in the window |
| fetch_pc | input | PC_W | Address of byte 0 |
| fetch_take | output | 1 | Window consumed this cycle |
| dec_ready | input | 1 | Downstream accepts the held result |
| dec_valid | output | 1 | Held result is valid |
| dec_word | output | 32 | Normalized instruction word |
| dec_ext | output | 24 | Extension field |
| dec_len | output | 3 | Instruction length in bytes (0 when illegal) |
| dec_illegal | output | 1 | Opcode byte is not in any class |
| dec_next_pc | output | PC_W | Address of the following instruction |

## Verification
Draining the held result and loading a fresh window can happen on the same clock edge. The bench provokes this by stalling `dec_ready` low while a second full window waits on the inputs. It then checks that the outputs and `fetch_take` stay frozen, and that raising `dec_ready` takes the waiting window in that cycle and shows its decode one cycle later. Two cases are judged against the expected decode: a window that falls below seven bytes while the stage empties must leave `dec_valid` low, and a program counter near the top of the address space must wrap in `dec_next_pc`.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    localparam int WORD_W  = 32;
    localparam int EXT_W   = 24;
    localparam int LEN_W   = 3;
    localparam int MIN_WIN = 7;

    typedef enum logic [3:0] {
        FMT_BAD,
        FMT_B1,
        FMT_B2,
        FMT_B3_LE,
        FMT_B3_BE,
        FMT_B4,
        FMT_B5_MID,
        FMT_B5_TAIL,
        FMT_B6,
        FMT_B7_AT1,
        FMT_B7_AT2
    } pdec_fmt_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [EXT_W-1:0]  ext;
        logic [LEN_W-1:0]  len;
        logic              illegal;
    } pdec_res_t;

    typedef logic [MIN_WIN-1:0][7:0] pdec_win_t;

    function automatic logic [LEN_W-1:0] pdec_len(input pdec_fmt_e f);
        case (f)
            FMT_B1:                  return LEN_W'(1);
            FMT_B2:                  return LEN_W'(2);
            FMT_B3_LE, FMT_B3_BE:    return LEN_W'(3);
            FMT_B4:                  return LEN_W'(4);
            FMT_B5_MID, FMT_B5_TAIL: return LEN_W'(5);
            FMT_B6:                  return LEN_W'(6);
            FMT_B7_AT1, FMT_B7_AT2:  return LEN_W'(7);
            default:                 return '0;
        endcase
    endfunction

endpackage

// File: rtl/pdec_classify.sv
module pdec_classify
    import pdec_pkg::*;
(
    input  logic [7:0] op,
    output pdec_fmt_e  fmt
);

    always_comb begin
        fmt = FMT_BAD;
        if (op inside {[8'h80:8'hbf]}) begin
            // register-field pair: equal fields select the two-byte form
            fmt = (op[3:2] == op[1:0]) ? FMT_B2 : FMT_B1;
        end else if (op inside {8'h00, 8'h04, 8'h08, 8'h0c, [8'h10:8'h1f],
                                [8'h3c:8'h3f], 8'h40, 8'h41, 8'h44, 8'h45,
                                8'h48, 8'h49, 8'h4c, 8'h4d, [8'h50:8'h57],
                                [8'h60:8'h7f], 8'hcb, [8'hd0:8'hdb],
                                [8'he0:8'hef], 8'hff}) begin
            fmt = FMT_B1;
        end else if (op inside {[8'h20:8'h23], [8'h28:8'h2b], 8'h42, 8'h43,
                                8'h46, 8'h47, 8'h4a, 8'h4b, 8'h4e, 8'h4f,
                                [8'h58:8'h5f], [8'hc0:8'hca], 8'hce, 8'hcf,
                                [8'hf0:8'hf6]}) begin
            fmt = FMT_B2;
        end else if (op inside {[8'h01:8'h03], [8'h05:8'h07], [8'h09:8'h0b],
                                [8'h0d:8'h0f], [8'h24:8'h27], [8'h2c:8'h3b],
                                8'hcc}) begin
            fmt = FMT_B3_LE;
        end else if (op inside {8'hde, 8'hdf, 8'hf8, 8'hf9}) begin
            fmt = FMT_B3_BE;
        end else if (op inside {8'hfa, 8'hfb}) begin
            fmt = FMT_B4;
        end else if (op == 8'hcd) begin
            fmt = FMT_B5_MID;
        end else if (op == 8'hdc) begin
            fmt = FMT_B5_TAIL;
        end else if (op inside {8'hfc, 8'hfd}) begin
            fmt = FMT_B6;
        end else if (op == 8'hdd) begin
            fmt = FMT_B7_AT1;
        end else if (op == 8'hfe) begin
            fmt = FMT_B7_AT2;
        end
    end

endmodule

// File: rtl/pdec_assemble.sv
module pdec_assemble
    import pdec_pkg::*;
(
    input  pdec_fmt_e fmt,
    input  pdec_win_t win,
    output pdec_res_t res
);

    logic four_be;

    // four-byte form packed big-endian when the first halfword masked by 0xfffc hits f0/f4/f8
    assign four_be = (win[0] == 8'hfa) && (win[1][7:2] inside {6'h3c, 6'h3d, 6'h3e});

    always_comb begin
        res         = '0;
        res.len     = pdec_len(fmt);
        res.illegal = (fmt == FMT_BAD);
        case (fmt)
            FMT_B1:      res.word = {24'h0, win[0]};
            FMT_B2:      res.word = {16'h0, win[0], win[1]};
            FMT_B3_LE:   res.word = {8'h0, win[0], win[2], win[1]};
            FMT_B3_BE:   res.word = {8'h0, win[0], win[1], win[2]};
            FMT_B4:      res.word = four_be ? {win[0], win[1], win[2], win[3]}
                                            : {win[0], win[1], win[3], win[2]};
            FMT_B5_MID: begin
                res.word = {win[0], win[2], win[1], win[3]};
                res.ext  = {16'h0, win[4]};
            end
            FMT_B5_TAIL: begin
                res.word = {win[0], win[4], win[3], win[2]};
                res.ext  = {16'h0, win[1]};
            end
            FMT_B6: begin
                res.word = {win[0], win[1], win[5], win[4]};
                res.ext  = {8'h0, win[3], win[2]};
            end
            FMT_B7_AT1: begin
                res.word = {win[0], win[4], win[3], win[2]};
                res.ext  = {win[1], win[5], win[6]};
            end
            FMT_B7_AT2: begin
                res.word = {win[0], win[1], win[5], win[4]};
                res.ext  = {win[3], win[2], win[6]};
            end
            default:     res.word = '0;
        endcase
    end

endmodule

// File: rtl/pdec_stage.sv
module pdec_stage
    import pdec_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            avail_ok,
    input  logic            down_ready,
    input  pdec_res_t       res_in,
    input  logic [PC_W-1:0] pc_in,
    output logic            take,
    output logic            valid,
    output pdec_res_t       res_out,
    output logic [PC_W-1:0] next_pc
);

    assign take = avail_ok && (!valid || down_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            res_out <= '0;
            next_pc <= '0;
        end else if (take) begin
            valid   <= 1'b1;
            res_out <= res_in;
            next_pc <= pc_in + PC_W'(res_in.len);
        end else if (down_ready) begin
            valid   <= 1'b0;
        end
    end

endmodule

// File: rtl/insn_predecode.sv
module insn_predecode
    import pdec_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int WIN_BYTES = 7,
    localparam int WIN_W    = WIN_BYTES * 8,
    localparam int AVAIL_W  = $clog2(WIN_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIN_W-1:0]   fetch_bytes,
    input  logic [AVAIL_W-1:0] fetch_avail,
    input  logic [PC_W-1:0]    fetch_pc,
    output logic               fetch_take,
    input  logic               dec_ready,
    output logic               dec_valid,
    output logic [WORD_W-1:0]  dec_word,
    output logic [EXT_W-1:0]   dec_ext,
    output logic [LEN_W-1:0]   dec_len,
    output logic               dec_illegal,
    output logic [PC_W-1:0]    dec_next_pc
);

    // WIN_BYTES must be at least MIN_WIN; only the first MIN_WIN bytes are decoded
    pdec_win_t  win;
    pdec_fmt_e  fmt;
    pdec_res_t  res_d;
    pdec_res_t  res_q;
    logic       avail_ok;

    for (genvar i = 0; i < MIN_WIN; i++) begin : g_unpack
        assign win[i] = fetch_bytes[8*i +: 8];
    end

    assign avail_ok = (int'(fetch_avail) >= MIN_WIN);

    pdec_classify u_classify (
        .op  (win[0]),
        .fmt (fmt)
    );

    pdec_assemble u_assemble (
        .fmt (fmt),
        .win (win),
        .res (res_d)
    );

    pdec_stage #(.PC_W(PC_W)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .avail_ok   (avail_ok),
        .down_ready (dec_ready),
        .res_in     (res_d),
        .pc_in      (fetch_pc),
        .take       (fetch_take),
        .valid      (dec_valid),
        .res_out    (res_q),
        .next_pc    (dec_next_pc)
    );

    assign dec_word    = res_q.word;
    assign dec_ext     = res_q.ext;
    assign dec_len     = res_q.len;
    assign dec_illegal = res_q.illegal;

endmodule

// File: rtl/pdec_chk.sv
module pdec_chk #(
    parameter int PC_W    = 32,
    parameter int AVAIL_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [AVAIL_W-1:0] fetch_avail,
    input logic [PC_W-1:0]    fetch_pc,
    input logic               fetch_take,
    input logic               dec_ready,
    input logic               dec_valid,
    input logic [31:0]        dec_word,
    input logic [23:0]        dec_ext,
    input logic [2:0]         dec_len,
    input logic               dec_illegal,
    input logic [PC_W-1:0]    dec_next_pc
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !dec_valid);

    // R2
    take_load_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_take |=> dec_valid);

    // R2
    starve_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec_valid && (int'(fetch_avail) < 7)) |=> !dec_valid);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_word) && $stable(dec_ext)
                                       && $stable(dec_len) && $stable(dec_illegal)
                                       && $stable(dec_next_pc)));

    // R4
    one_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_len == 3'd1) |-> (dec_word[31:8] == 24'h0 && dec_ext == 24'h0));

    // R12
    illegal_len_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_illegal) |-> (dec_len == 3'd0));

    // R12
    legal_len_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_illegal) |-> (dec_len != 3'd0));

    // R13
    next_pc_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_take |=> (dec_next_pc == $past(fetch_pc) + PC_W'(dec_len)));

endmodule

bind insn_predecode pdec_chk #(.PC_W(PC_W), .AVAIL_W(AVAIL_W)) u_pdec_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_avail (fetch_avail),
    .fetch_pc    (fetch_pc),
    .fetch_take  (fetch_take),
    .dec_ready   (dec_ready),
    .dec_valid   (dec_valid),
    .dec_word    (dec_word),
    .dec_ext     (dec_ext),
    .dec_len     (dec_len),
    .dec_illegal (dec_illegal),
    .dec_next_pc (dec_next_pc)
);

// File: tb/test_insn_predecode.sv
module test_insn_predecode;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [6:0][7:0]   w   = '0;
    logic [2:0]        avail = '0;
    logic [31:0]       pc  = '0;
    logic              take;
    logic              ready = 1'b1;
    logic              valid;
    logic [31:0]       word;
    logic [23:0]       ext;
    logic [2:0]        len;
    logic              ill;
    logic [31:0]       npc;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    insn_predecode i_insn_predecode (
        .clk         (clk),
        .rst         (rst),
        .fetch_bytes (w),
        .fetch_avail (avail),
        .fetch_pc    (pc),
        .fetch_take  (take),
        .dec_ready   (ready),
        .dec_valid   (valid),
        .dec_word    (word),
        .dec_ext     (ext),
        .dec_len     (len),
        .dec_illegal (ill),
        .dec_next_pc (npc)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // expected decode, built from the requirement text
    function automatic void model(input logic [6:0][7:0] b, output logic [31:0] ew,
                                  output logic [23:0] ee, output logic [2:0] el,
                                  output logic ei, output string tag);
        logic [31:0] v1, v2;
        v1 = 32'(b[1]) | (32'(b[2]) << 8) | (32'(b[3]) << 16) | (32'(b[4]) << 24);
        v2 = 32'(b[2]) | (32'(b[3]) << 8) | (32'(b[4]) << 16) | (32'(b[5]) << 24);
        ew = 0; ee = 0; el = 0; ei = 0;
        if (b[0] >= 8'h80 && b[0] <= 8'hbf) begin
            if (((b[0] >> 2) & 3) == (b[0] & 3)) begin
                tag = "R5"; el = 2; ew = 32'(b[0]) * 256 + 32'(b[1]);
            end else begin
                tag = "R4"; el = 1; ew = 32'(b[0]);
            end
        end else case (b[0]) inside
            8'h00, 8'h04, 8'h08, 8'h0c, [8'h10:8'h1f], [8'h3c:8'h3f], 8'h40, 8'h41,
            8'h44, 8'h45, 8'h48, 8'h49, 8'h4c, 8'h4d, [8'h50:8'h57], [8'h60:8'h7f],
            8'hcb, [8'hd0:8'hdb], [8'he0:8'hef], 8'hff: begin
                tag = "R4"; el = 1; ew = 32'(b[0]);
            end
            [8'h20:8'h23], [8'h28:8'h2b], 8'h42, 8'h43, 8'h46, 8'h47, 8'h4a, 8'h4b,
            8'h4e, 8'h4f, [8'h58:8'h5f], [8'hc0:8'hca], 8'hce, 8'hcf, [8'hf0:8'hf6]: begin
                tag = "R5"; el = 2; ew = 32'(b[0]) * 256 + 32'(b[1]);
            end
            [8'h01:8'h03], [8'h05:8'h07], [8'h09:8'h0b], [8'h0d:8'h0f], [8'h24:8'h27],
            [8'h2c:8'h3b], 8'hcc: begin
                tag = "R6"; el = 3; ew = 32'(b[0]) * 65536 + 32'(b[2]) * 256 + 32'(b[1]);
            end
            8'hde, 8'hdf, 8'hf8, 8'hf9: begin
                tag = "R7"; el = 3; ew = 32'(b[0]) * 65536 + 32'(b[1]) * 256 + 32'(b[2]);
            end
            8'hfa, 8'hfb: begin
                tag = "R8"; el = 4;
                if (b[0] == 8'hfa && b[1] >= 8'hf0 && b[1] <= 8'hfb)
                    ew = (32'(b[0]) << 24) | (32'(b[1]) << 16) | (32'(b[2]) << 8) | 32'(b[3]);
                else
                    ew = (32'(b[0]) << 24) | (32'(b[1]) << 16) | (32'(b[3]) << 8) | 32'(b[2]);
            end
            8'hcd: begin
                tag = "R9"; el = 5;
                ew = (32'(b[0]) << 24) | ((32'(b[1]) | (32'(b[2]) << 8)) << 8) | 32'(b[3]);
                ee = 24'(b[4]);
            end
            8'hdc: begin
                tag = "R9"; el = 5;
                ew = (32'(b[0]) << 24) | (v1 >> 8); ee = 24'(v1 & 32'hff);
            end
            8'hfc, 8'hfd: begin
                tag = "R10"; el = 6;
                ew = (32'(b[0]) << 24) | (32'(b[1]) << 16) | (v2 >> 16); ee = 24'(v2 & 32'hffff);
            end
            8'hdd: begin
                tag = "R11"; el = 7;
                ew = (32'(b[0]) << 24) | (v1 >> 8);
                ee = 24'(((v1 & 32'hff) << 16) | (32'(b[5]) << 8) | 32'(b[6]));
            end
            8'hfe: begin
                tag = "R11"; el = 7;
                ew = (32'(b[0]) << 24) | (32'(b[1]) << 16) | (v2 >> 16);
                ee = 24'(((v2 << 8) & 32'hffff00) | 32'(b[6]));
            end
            default: begin
                tag = "R12"; ei = 1;
            end
        endcase
    endfunction

    function automatic logic [6:0][7:0] fill(input int op, input int seed);
        logic [6:0][7:0] r;
        r[0] = 8'(op);
        for (int i = 1; i < 7; i++) r[i] = 8'(op * 37 + i * 53 + seed * 101 + 7);
        return r;
    endfunction

    // offer a window with ready high, then check the decode one cycle later
    task automatic step(input logic [6:0][7:0] b, input logic [31:0] p);
        logic [31:0] ew; logic [23:0] ee; logic [2:0] el; logic ei; string tag;
        w = b; pc = p; avail = 3'd7; ready = 1'b1;
        model(b, ew, ee, el, ei, tag);
        @(negedge clk);
        check(valid == 1'b1, "R2", "valid after take", 64'(valid), 64'd1);
        check({word, ext, el == len, ill} == {ew, ee, 1'b1, ei}, tag, "decode",
              {word, ext, 5'(len), ill, 3'd0}, {ew, ee, 5'(el), ei, 3'd0});
        check(npc == p + 32'(el), "R13", "next pc", 64'(npc), 64'(p + 32'(el)));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL R2 watchdog actual=hung expected=finished");
                $display("Result: errors=%0d of %0d checks", errors, checks + 1);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] ew_a; logic [23:0] ee_a; logic [2:0] el_a; logic ei_a; string tg;
        logic [6:0][7:0] wa, wb;
        repeat (3) @(negedge clk);
        check(valid == 1'b0, "R1", "valid in reset", 64'(valid), 64'd0);
        check(take == 1'b0, "R1", "take with empty window", 64'(take), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(valid == 1'b0, "R1", "valid after reset", 64'(valid), 64'd0);

        // sweep of every opcode byte, two fillers, one pc near the wrap point
        for (int op = 0; op < 256; op++) begin
            for (int s = 0; s < 2; s++) begin
                step(fill(op, s), (s == 1) ? 32'hffff_fffc : 32'(op * 13 + 32'h100));
            end
        end

        // R8: every second byte for both four-byte opcodes
        for (int op = 8'hfa; op <= 8'hfb; op++) begin
            for (int sb = 0; sb < 256; sb++) begin
                wa = fill(op, sb);
                wa[1] = 8'(sb);
                step(wa, 32'h4000 + 32'(sb));
            end
        end

        // R3: stall with a second window waiting, then drain and load on one edge
        wa = fill(8'hdd, 3);
        wb = fill(8'h2e, 4);
        step(wa, 32'h8000);
        model(wa, ew_a, ee_a, el_a, ei_a, tg);
        ready = 1'b0; w = wb; pc = 32'h9000; avail = 3'd7;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(take == 1'b0, "R3", "take while stalled", 64'(take), 64'd0);
            check(valid && word == ew_a && ext == ee_a && npc == 32'h8007, "R3",
                  "held outputs", {word, 8'(ext)}, {ew_a, 8'(ee_a)});
        end
        ready = 1'b1;
        #1;
        check(take == 1'b1, "R3", "take on drain", 64'(take), 64'd1);
        model(wb, ew_a, ee_a, el_a, ei_a, tg);
        @(negedge clk);
        check(valid && word == ew_a && npc == 32'h9003, "R3", "window after drain",
              {word, npc}, {ew_a, 32'h9003});

        // R2: fewer than seven bytes leaves the stage empty
        avail = 3'd6;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(valid == 1'b0, "R2", "valid with short window", 64'(valid), 64'd0);
            check(take == 1'b0, "R2", "take with short window", 64'(take), 64'd0);
        end
        step(fill(8'hfe, 9), 32'h1234);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule